// File: doc/BRIEF.md
# Codec Serial Frame Port

This block is the device side of the serial link between a voice codec and its host. It generates the bit clock itself and divides time into frames of 256 bit clocks. The first 16 bit clocks of every frame carry one audio sample in each direction. The block hands the received sample to the codec datapath on a parallel port, and it shifts the datapath's sample out to the host.

The host can ask for a control slot by setting the least significant bit of the audio word it sends. The control slot then opens 128 bit clocks after the frame start of the same frame. In it, one 16-bit command reads or writes one byte of a small internal register file. The rest of the chip reads that register file through a parallel configuration read port.

A static mode input selects how the frame sync is shaped and whether the outbound audio word gives up its last bit. A register bit can turn on a digital loopback, which sends the previous frame's received audio back out in place of the datapath sample.

Top module: `codec_frame_port`

## Requirements
- R1: `sclk` toggles on every `clk` cycle, so one bit period lasts two clocks, and a frame lasts 256 bit periods. `sdo` and `sdoOe` change only where `sclk` rises. In bit periods 0..15 of each frame `sdoOe` is 1 and `sdo` carries the outbound audio word, most significant bit first. In modes 0, 1 and 3 with loopback off, that word is `txSample` as sampled at the start of bit 0.
- R2: `sdi` is sampled where `sclk` falls. After bit 15 has been sampled, `rxSample` holds inbound bits 15..1 of the audio word, and `rxValid` pulses high for exactly one clock, once per frame.
- R3: Inbound audio bit 0 is a request flag. When it is 1, a control slot spans bit periods 128..143 of the same frame. When it is 0, no slot opens: `sdoOe` stays 0, the frame sync stays low in that span, and `sdi` there has no effect on any register.
- R4: The inbound control word is laid out as follows: bits 15:14 must be 00, bit 13 selects read (1) or write (0), bits 12:8 hold the register address, and bits 7:0 hold the write data. A word whose bits 15:14 are not 00 neither writes a register nor drives `sdo`.
- R5: During a read slot, `sdoOe` is 0 for bit periods 128..135. For periods 136..143 it is 1, and `sdo` carries the addressed byte, most significant bit first. Outside the audio slot and the read data bits, `sdoOe` is 0.
- R6: A write stores its data at the end of the slot. From the next frame on, the value shows on `cfgData` for that `cfgAddr` and in later serial reads.
- R7: Register address 0 always reads 0 and ignores writes. Addresses 8..31 read 0 and ignore writes.
- R8: Only writable bits are stored, and reserved bits read 0. Register 1 keeps bits 6:1, register 7 keeps bits 3:0, and registers 2..6 keep all 8 bits. The reset value of register n (n = 1..7) is 0x11*n masked by its writable bits.
- R9: A write to register 1 with bit 7 set restores every register to its reset value, and the written byte itself is discarded. Bit 7 of register 1 always reads 0.
- R10: `modeSel` 0 and 3 hold `fsync` high for all 16 bit periods of each present slot. Mode 1 raises `fsync` for the first bit period of each present slot only. Mode 2 frames like mode 0 and forces bit 0 of the outbound audio word to 0.
- R11: When register 1 bit 1 is set, the outbound audio word is the previous frame's inbound bits 15..1 followed by a 0, in place of `txSample`.
- R12: While `rstN` is low, `sclk`, `fsync`, `sdoOe` and `rxValid` are 0, and the registers hold their reset values. The first rising `sclk` after release starts bit period 0 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, twice the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Static frame sync / slave mode select |
| txSample | input | 16 | Audio sample from the datapath toward the host |
| rxSample | output | 15 | Audio received from the host (inbound bits 15..1) |
| rxValid | output | 1 | One-clock strobe when `rxSample` is updated |
| sclk | output | 1 | Bit clock driven to the host |
| fsync | output | 1 | Frame sync driven to the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data toward the host |
| sdoOe | output | 1 | Drive enable for `sdo`; 0 means high impedance |
| cfgAddr | input | 5 | Register address for the configuration read port |
| cfgData | output | 8 | Register contents at `cfgAddr` |

## Verification
The bench plays the host. It drives frames that raise and clear the request flag, and it checks that an unrequested slot neither drives `sdo` nor changes a register; a block that trusts the slot position alone would accept stray writes. It also sends commands with nonzero guard bits, accesses register 0, accesses addresses past the last register, and writes reserved bits, where a loose decoder would drive data or store bits that must stay zero. It checks that the read byte shows up on the second half of the slot only, which fails if the block turns on the driver during the header. Finally it runs loopback and software reset back to back, so a wrong latency, or a reset that fails to clear the loopback bit, shows up as a wrong outbound word.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  // frame geometry (SEC_START must be a multiple of WORD_W)
  localparam int WORD_W     = 16;
  localparam int FRAME_LEN  = 256;
  localparam int SEC_START  = 128;
  localparam int HEAD_W     = 8;
  localparam int CNT_W      = $clog2(FRAME_LEN);
  localparam int POS_W      = $clog2(WORD_W);

  // register file
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  localparam int REG_COUNT  = 8;
  localparam int IDX_W      = $clog2(REG_COUNT);
  localparam int BYTE_POS_W = $clog2(DATA_W);
  localparam int CTRL_REG   = 1;
  localparam int RST_BIT    = 7;
  localparam int LOOP_BIT   = 1;
  localparam logic [DATA_W-1:0] CTRL_MASK = 8'h7E;
  localparam logic [DATA_W-1:0] TAIL_MASK = 8'h0F;

  typedef enum logic [1:0] {
    MODE_SPAN  = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_SLAVE = 2'd2,
    MODE_ALT   = 2'd3
  } fsMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic             rise;    // this edge raises sclk, bitIdx is the new period
    logic             fall;    // this edge lowers sclk, bitIdx is the current period
    logic [CNT_W-1:0] bitIdx;
    logic             secOn;   // control slot requested in this frame
    logic             zeroLsb; // slave mode: clear outbound audio bit 0
  } portStrobe_t;
endpackage

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
  import sfp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  modeSel,
  input  logic        sdi,
  output logic        sclk,
  output logic        fsync,
  output portStrobe_t strobe
);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] PRIM_END  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] PRIM_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] SEC_BEG   = CNT_W'(SEC_START);
  localparam logic [CNT_W-1:0] SEC_END   = CNT_W'(SEC_START + WORD_W);

  logic             phase;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] nextBit;
  logic             secReq;
  logic             pulseMode;
  logic             primWin;
  logic             secWin;
  logic             fsyncNext;

  assign nextBit   = (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
  assign pulseMode = (fsMode_e'(modeSel) == MODE_PULSE);
  assign primWin   = (nextBit < PRIM_END);
  assign secWin    = secReq && (nextBit >= SEC_BEG) && (nextBit < SEC_END);

  always_comb begin
    if (pulseMode)
      fsyncNext = (nextBit == '0) || (secReq && (nextBit == SEC_BEG));
    else
      fsyncNext = primWin || secWin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= 1'b0;
      bitCnt <= LAST_BIT;
      secReq <= 1'b0;
      fsync  <= 1'b0;
    end else begin
      phase <= !phase;
      if (!phase) begin
        bitCnt <= nextBit;
        fsync  <= fsyncNext;
      end else if (bitCnt == PRIM_LAST) begin
        secReq <= sdi;
      end
    end
  end

  assign sclk = phase;

  always_comb begin
    strobe.rise    = !phase;
    strobe.fall    = phase;
    strobe.bitIdx  = phase ? bitCnt : nextBit;
    strobe.secOn   = secReq;
    strobe.zeroLsb = (fsMode_e'(modeSel) == MODE_SLAVE);
  end
endmodule

// File: rtl/sfp_regfile.sv
module sfp_regfile
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              loopOn
);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(REG_COUNT);

  function automatic logic [DATA_W-1:0] maskOf(input int idx);
    if (idx == 0)              return '0;
    if (idx == CTRL_REG)       return CTRL_MASK;
    if (idx == REG_COUNT - 1)  return TAIL_MASK;
    return '1;
  endfunction

  function automatic logic [DATA_W-1:0] defaultOf(input int idx);
    return DATA_W'(idx * 17) & maskOf(idx);
  endfunction

  logic [DATA_W-1:0] regQ [REG_COUNT];
  logic              swRst;

  assign swRst = we && (wAddr == ADDR_W'(CTRL_REG)) && wData[RST_BIT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regQ[g] <= defaultOf(g);
      else if (swRst)
        regQ[g] <= defaultOf(g);
      else if (we && (wAddr == ADDR_W'(g)))
        regQ[g] <= wData & maskOf(g);
    end
  end

  assign rdDataA = (rdAddrA < LIMIT) ? regQ[rdAddrA[IDX_W-1:0]] : '0;
  assign rdDataB = (rdAddrB < LIMIT) ? regQ[rdAddrB[IDX_W-1:0]] : '0;
  assign loopOn  = regQ[CTRL_REG][LOOP_BIT];
endmodule

// File: rtl/sfp_datapath.sv
module sfp_datapath
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic              sdi,
  input  logic [WORD_W-1:0] txSample,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic              sdo,
  output logic              sdoOe,
  output logic [WORD_W-2:0] rxSample,
  output logic              rxValid,
  output logic [DATA_W-1:0] cfgData
);
  localparam logic [CNT_W-1:0] PRIM_END   = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] SEC_BEG    = CNT_W'(SEC_START);
  localparam logic [CNT_W-1:0] SEC_END    = CNT_W'(SEC_START + WORD_W);
  localparam logic [POS_W-1:0] POS_LAST   = POS_W'(WORD_W - 1);
  localparam logic [POS_W-1:0] HEAD_LAST  = POS_W'(HEAD_W - 1);
  localparam logic [POS_W-1:0] DATA_FIRST = POS_W'(HEAD_W);

  logic [CNT_W-1:0]  idx;
  logic [POS_W-1:0]  pos;
  logic              inPrim;
  logic              inSec;
  logic [WORD_W-2:0] rxShift;
  logic [WORD_W-1:0] shiftIn;
  logic [HEAD_W-1:0] cmdHead;
  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] loadWord;
  logic [WORD_W-2:0] rxAudio;
  logic              cmdRead;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] rdByte;
  logic [DATA_W-1:0] rdDataA;
  logic [DATA_W-1:0] rdSel;
  logic              loopOn;
  logic              regWe;
  logic [ADDR_W-1:0] regWAddr;
  logic [DATA_W-1:0] regWData;

  assign idx     = strobe.bitIdx;
  assign pos     = idx[POS_W-1:0];
  assign inPrim  = (idx < PRIM_END);
  assign inSec   = strobe.secOn && (idx >= SEC_BEG) && (idx < SEC_END);
  assign shiftIn = {rxShift, sdi};
  assign cmdHead = shiftIn[HEAD_W-1:0];
  assign rdSel   = (pos == DATA_FIRST) ? rdDataA : rdByte;

  // write decode on the last sampled bit of the control slot
  assign regWe    = strobe.fall && inSec && (pos == POS_LAST) &&
                    (shiftIn[WORD_W-1 -: 2] == 2'b00) && !shiftIn[WORD_W-3];
  assign regWAddr = shiftIn[DATA_W +: ADDR_W];
  assign regWData = shiftIn[DATA_W-1:0];

  always_comb begin
    loadWord = loopOn ? {rxAudio, 1'b0} : txSample;
    if (strobe.zeroLsb)
      loadWord[0] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sdo     <= 1'b0;
      sdoOe   <= 1'b0;
      txWord  <= '0;
      rxShift <= '0;
      rxAudio <= '0;
      rxValid <= 1'b0;
      cmdRead <= 1'b0;
      cmdAddr <= '0;
      rdByte  <= '0;
    end else begin
      rxValid <= 1'b0;
      if (strobe.rise) begin
        if (inPrim) begin
          sdoOe <= 1'b1;
          if (pos == '0) begin
            txWord <= loadWord;
            sdo    <= loadWord[WORD_W-1];
          end else begin
            sdo <= txWord[~pos];
          end
        end else if (inSec && (pos >= DATA_FIRST)) begin
          sdoOe <= cmdRead;
          sdo   <= rdSel[~pos[BYTE_POS_W-1:0]];
          if (pos == DATA_FIRST)
            rdByte <= rdDataA;
        end else begin
          sdoOe <= 1'b0;
          sdo   <= 1'b0;
        end
      end
      if (strobe.fall && (inPrim || inSec)) begin
        rxShift <= shiftIn[WORD_W-2:0];
        if (inPrim && (pos == POS_LAST)) begin
          rxAudio <= shiftIn[WORD_W-1:1];
          rxValid <= 1'b1;
        end
        if (inSec && (pos == HEAD_LAST)) begin
          cmdRead <= (cmdHead[HEAD_W-1 -: 2] == 2'b00) && cmdHead[HEAD_W-3];
          cmdAddr <= cmdHead[ADDR_W-1:0];
        end
      end
    end
  end

  assign rxSample = rxAudio;

  sfp_regfile i_regs (
    .clk     (clk),
    .rstN    (rstN),
    .we      (regWe),
    .wAddr   (regWAddr),
    .wData   (regWData),
    .rdAddrA (cmdAddr),
    .rdDataA (rdDataA),
    .rdAddrB (cfgAddr),
    .rdDataB (cfgData),
    .loopOn  (loopOn)
  );
endmodule

// File: rtl/codec_frame_port.sv
module codec_frame_port
  import sfp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic [WORD_W-1:0] txSample,
  output logic [WORD_W-2:0] rxSample,
  output logic              rxValid,
  output logic              sclk,
  output logic              fsync,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  input  logic [ADDR_W-1:0] cfgAddr,
  output logic [DATA_W-1:0] cfgData
);
  portStrobe_t strobe;

  sfp_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .sdi     (sdi),
    .sclk    (sclk),
    .fsync   (fsync),
    .strobe  (strobe)
  );

  sfp_datapath i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .sdi      (sdi),
    .txSample (txSample),
    .cfgAddr  (cfgAddr),
    .sdo      (sdo),
    .sdoOe    (sdoOe),
    .rxSample (rxSample),
    .rxValid  (rxValid),
    .cfgData  (cfgData)
  );
endmodule

// File: rtl/codec_frame_port_chk.sv
module codec_frame_port_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       sclk,
  input logic       fsync,
  input logic       sdo,
  input logic       sdoOe,
  input logic       rxValid
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R1
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    sclk != $past(sclk));

  // R1
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !sclk |-> $stable(sdo));

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !sclk |-> $stable(sdoOe));

  // R10
  fs_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !sclk |-> $stable(fsync));

  // R2
  rxv_fall_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    rxValid |-> !sclk);

  // R2
  rxv_pulse_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    rxValid |=> !rxValid);

  // R10
  fs_pulse_chk: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (modeSel == 2'd1 && $rose(fsync)) |=> fsync ##1 !fsync);
endmodule

bind codec_frame_port codec_frame_port_chk i_chk (.*);

// File: tb/test_codec_frame_port.sv
module test_codec_frame_port;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] tx;
    logic [15:0] pw;
    logic [15:0] sw;
    logic        rdOe;
    logic [7:0]  rd;
  } vec_t;

  // mode 0 table walk: outbound word, control access, expected read byte
  localparam vec_t VECS [13] = '{
    '{16'hA5C3, 16'h1234, 16'h0000, 1'b0, 8'h00},  // R3 no request
    '{16'h5A3C, 16'h8001, 16'h2200, 1'b1, 8'h22},  // R5 read reg2 default
    '{16'hFFFF, 16'h7FFF, 16'h03A7, 1'b0, 8'h00},  // R6 write reg3
    '{16'h0001, 16'h0003, 16'h2300, 1'b1, 8'hA7},  // R6 read back
    '{16'h8000, 16'h0001, 16'h00FF, 1'b0, 8'h00},  // R7 write reg0
    '{16'h1111, 16'h0001, 16'h2000, 1'b1, 8'h00},  // R7 read reg0
    '{16'h2222, 16'h0001, 16'h07FF, 1'b0, 8'h00},  // R8 write reg7
    '{16'h3333, 16'h0001, 16'h2700, 1'b1, 8'h0F},  // R8 reserved bits zero
    '{16'h4444, 16'h0001, 16'hA200, 1'b0, 8'h00},  // R4 guard bits set, read
    '{16'h6666, 16'h0000, 16'h0355, 1'b0, 8'h00},  // R3 write without request
    '{16'h5555, 16'h0001, 16'h4355, 1'b0, 8'h00},  // R4 guard bits set, write
    '{16'h7777, 16'h0001, 16'h2300, 1'b1, 8'hA7},  // R3 R4 reg3 untouched
    '{16'h9999, 16'h0001, 16'h2900, 1'b1, 8'h00}   // R7 address past end
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [15:0] txSample = '0;
  logic [14:0] rxSample;
  logic        rxValid;
  logic        sclk;
  logic        fsync;
  logic        sdi = 1'b0;
  logic        sdo;
  logic        sdoOe;
  logic [4:0]  cfgAddr = '0;
  logic [7:0]  cfgData;

  int nTests = 0;
  int nFail  = 0;
  logic curS = 1'b0;
  logic prevS = 1'b0;
  int rxvCount;
  logic capSdo [256];
  logic capOe  [256];
  logic capFs  [256];

  always #(CLK_PERIOD/2) clk = !clk;

  codec_frame_port i_codec_frame_port (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .txSample(txSample),
    .rxSample(rxSample), .rxValid(rxValid), .sclk(sclk), .fsync(fsync),
    .sdi(sdi), .sdo(sdo), .sdoOe(sdoOe), .cfgAddr(cfgAddr), .cfgData(cfgData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitRise();
    do begin
      @(negedge clk);
      if (rxValid) rxvCount++;
      prevS = curS;
      curS  = sclk;
    end while (!(curS && !prevS));
  endtask

  // host side of one frame: capture outputs per bit period and drive sdi
  task automatic doFrame(input logic [15:0] pw, input logic [15:0] sw);
    rxvCount = 0;
    for (int b = 0; b < 256; b++) begin
      waitRise();
      capSdo[b] = sdo;
      capOe[b]  = sdoOe;
      capFs[b]  = fsync;
      if (b < 16)                 sdi = pw[15-b];
      else if (b >= 128 && b < 144) sdi = sw[143-b];
      else                        sdi = 1'b1;
    end
  endtask

  function automatic bit expFs(input int md, input bit req, input int b);
    if (md == 1) return (b == 0) || (req && b == 128);
    return (b < 16) || (req && b >= 128 && b < 144);
  endfunction

  task automatic checkFrame(input int md, input logic [15:0] expOut,
                            input logic [15:0] pw, input logic rdOe,
                            input logic [7:0] rd);
    logic [15:0] outW;
    logic [7:0]  rdW;
    int fsErr, primOe, stray, dataOe;
    fsErr = 0; primOe = 0; stray = 0; dataOe = 0;
    for (int b = 0; b < 256; b++) begin
      if (capFs[b] != expFs(md, pw[0], b)) fsErr++;
      if (b < 16) begin
        outW[15-b] = capSdo[b];
        if (capOe[b]) primOe++;
      end else if (b >= 136 && b < 144) begin
        rdW[143-b] = capSdo[b];
        if (capOe[b]) dataOe++;
      end else if (capOe[b]) begin
        stray++;
      end
    end
    chk(outW == expOut, "R1", "outbound audio word", outW, expOut);
    chk(primOe == 16, "R1", "audio slot drive count", primOe, 16);
    chk(fsErr == 0, "R10", "fsync mismatches", fsErr, 0);
    chk(stray == 0, "R5", "drive outside data bits", stray, 0);
    if (rdOe) begin
      chk(dataOe == 8, "R5", "read data drive count", dataOe, 8);
      chk(rdW == rd, "R5", "read byte", rdW, rd);
    end else begin
      chk(dataOe == 0, "R4", "no read drive", dataOe, 0);
    end
    chk(rxSample == pw[15:1], "R2", "rxSample", rxSample, pw[15:1]);
    chk(rxvCount == 1, "R2", "rxValid pulses", rxvCount, 1);
  endtask

  task automatic cfgCheck(input logic [4:0] a, input logic [7:0] exp,
                          input string req);
    cfgAddr = a;
    #1;
    chk(cfgData == exp, req, "cfgData", cfgData, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // R12 reset state
    repeat (4) @(negedge clk);
    chk(sclk == 1'b0 && fsync == 1'b0, "R12", "sclk/fsync in reset", {sclk, fsync}, 0);
    chk(sdoOe == 1'b0 && rxValid == 1'b0, "R12", "sdoOe/rxValid in reset", {sdoOe, rxValid}, 0);
    cfgCheck(5'd2, 8'h22, "R12");
    cfgCheck(5'd1, 8'h10, "R12");
    @(negedge clk);
    rstN = 1'b1;

    // table walk, mode 0
    for (int v = 0; v < 13; v++) begin
      txSample = VECS[v].tx;
      doFrame(VECS[v].pw, VECS[v].sw);
      checkFrame(0, VECS[v].tx, VECS[v].pw, VECS[v].rdOe, VECS[v].rd);
      if (!VECS[v].pw[0])
        chk(capFs[128] == 1'b0 && capOe[140] == 1'b0, "R3", "no slot without request",
            {capFs[128], capOe[140]}, 0);
    end
    cfgCheck(5'd3, 8'hA7, "R6");
    cfgCheck(5'd0, 8'h00, "R7");
    cfgCheck(5'd7, 8'h0F, "R8");
    cfgCheck(5'd9, 8'h00, "R7");

    // R10 slave mode clears outbound bit 0
    modeSel = 2'd2; txSample = 16'hFFFF;
    doFrame(16'h0001, 16'h0000);
    checkFrame(2, 16'hFFFE, 16'h0001, 1'b0, 8'h00);

    // R10 pulse mode with a read
    modeSel = 2'd1; txSample = 16'h1357;
    doFrame(16'h0001, 16'h2200);
    checkFrame(1, 16'h1357, 16'h0001, 1'b1, 8'h22);

    // R10 mode 3 frames like mode 0
    modeSel = 2'd3; txSample = 16'h2468;
    doFrame(16'h0000, 16'h0000);
    checkFrame(3, 16'h2468, 16'h0000, 1'b0, 8'h00);

    // R11 loopback on; R8 reserved bit 0 of register 1 dropped
    modeSel = 2'd0; txSample = 16'h0F0F;
    doFrame(16'hBEEF, 16'h0103);
    checkFrame(0, 16'h0F0F, 16'hBEEF, 1'b0, 8'h00);
    cfgCheck(5'd1, 8'h02, "R8");
    doFrame(16'h1234, 16'h0000);
    checkFrame(0, 16'hBEEE, 16'h1234, 1'b0, 8'h00);   // R11

    // R9 soft reset while looping in slave mode
    modeSel = 2'd2;
    doFrame(16'h5679, 16'h01FF);
    checkFrame(2, 16'h1234, 16'h5679, 1'b0, 8'h00);   // R11 one frame later
    cfgCheck(5'd1, 8'h10, "R9");
    cfgCheck(5'd3, 8'h33, "R9");
    cfgCheck(5'd7, 8'h07, "R9");
    modeSel = 2'd0;
    doFrame(16'h0000, 16'h0000);
    checkFrame(0, 16'h0F0F, 16'h0000, 1'b0, 8'h00);   // R9 loopback cleared

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule